// File: doc/BRIEF.md
# Edge-Timing Bit Check Validator

This block sits after a receiver's demodulator and decides whether the incoming serial stream looks like a real wake-up signal or just noise. It times every gap between successive edges of the demodulated data, counting in units of a sample-clock tick. Each gap must fall inside a window set by two programmable limits. A gap that is too short fails the check at the edge that ends it. A gap that is too long fails the check as soon as the counter reaches the upper limit, without waiting for the edge.

When enable rises, the block first runs a fixed start-up interval. The demodulator output is not trusted during that interval, so any edges in it are ignored. The block then enters the bit-check phase. The first edge in that phase only starts timing and is not measured. Every later edge ends one half-bit measurement. Once the selected number of bits has been validated (two measurements per bit), the block emits a pass pulse and reports receive mode. Any failed measurement emits a fail pulse and puts the block into sleep mode. It stays there until enable is taken low and raised again.

Top module: `bitcheck_validator`

## Requirements
- R1: After reset, and whenever enable is low, `mode` reads 0 (sleep) and both `passPulse` and `failPulse` are low. The mode codes are 0 = sleep, 1 = start-up, 2 = bit check, 3 = receive.
- R2: In the clock cycle after enable is seen high in idle, `mode` becomes 1. It stays 1 for exactly STARTUP_TICKS ticks and becomes 2 after the last of them. Edges during start-up cause no pulse.
- R3: In bit-check mode, no measurement runs before the first edge. Any number of edge-free ticks before it causes no fail, and that first edge is not checked against either limit.
- R4: An edge that ends a gap of fewer than `limMin` ticks produces a one-cycle `failPulse` and `mode` 0.
- R5: If `limMax`-1 ticks pass after an accepted edge with no further edge, the counter reaches `limMax`. `failPulse` fires on that tick and `mode` becomes 0.
- R6: A gap of k ticks, with `limMin` <= k <= `limMax`-1, is accepted without a pulse, and the counter restarts for the next gap. Both ends of this range are accepted.
- R7: `bitSel` chooses how many bits are checked: 0 selects 3, 1 selects 6, and 2 or 3 select 9. After twice that many accepted gaps, a one-cycle `passPulse` fires and `mode` becomes 3, with no pulse before that.
- R8: After a fail, `mode` stays 0 and no pulse appears while enable stays high, whatever the data does.
- R9: Taking enable low in any mode returns the block to idle in the next cycle and clears all its counters. The next run then starts from a full start-up interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces idle |
| tick | input | 1 | One-cycle sample-clock strobe |
| demodIn | input | 1 | Demodulated data, sampled on tick |
| limMin | input | 6 | Lowest accepted gap in ticks |
| limMax | input | 6 | Counter value at which a gap is too long |
| bitSel | input | 2 | Number-of-bits select |
| passPulse | output | 1 | One-cycle pulse on a passed check |
| failPulse | output | 1 | One-cycle pulse on a failed check |
| mode | output | 2 | 0 sleep, 1 start-up, 2 bit check, 3 receive |

## Verification
The bench probes both edges of the timing window. Gaps of limMin-1 and limMin ticks are tried, and so are limMax-1 edge-free ticks against limMax-2. A design with an off-by-one compare or a counter that restarts at 0 would accept a gap it should reject, or time out one tick early or late. The bench also sits through a long quiet stretch before the first bit-check edge, and toggles the data all through start-up. A design that evaluated those edges, or started timing without an edge, would fail spuriously. It counts the pass point for every bitSel code: a miscounted total would pass early or late. It drops enable mid-check to show that a stale start-up or gap counter does not carry into the next run.

// File: rtl/bitcheck_pkg.sv
package bitcheck_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STARTUP,
    ST_CHECK,
    ST_RECEIVE,
    ST_SLEEP
  } bcState_t;

  localparam logic [1:0] MODE_SLEEP   = 2'd0;
  localparam logic [1:0] MODE_STARTUP = 2'd1;
  localparam logic [1:0] MODE_CHECK   = 2'd2;
  localparam logic [1:0] MODE_RECEIVE = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic suInc;
    logic startTiming;
    logic cntInc;
    logic accept;
  } bcStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic suLast;
    logic timing;
    logic tooShort;
    logic tooLong;
    logic lastMeas;
  } bcStatus_t;

endpackage

// File: rtl/bitcheck_datapath.sv
module bitcheck_datapath
  import bitcheck_pkg::*;
#(
  parameter int LIM_W = 6,
  parameter int STARTUP_TICKS = 8,
  parameter int MEAS_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             demodIn,
  input  logic [LIM_W-1:0] limMin,
  input  logic [LIM_W-1:0] limMax,
  input  logic [1:0]       bitSel,
  input  bcStrobe_t        strobe,
  output bcStatus_t        status
);

  localparam int SU_W = $clog2(STARTUP_TICKS + 1);
  localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_TICKS - 1);

  logic              demodPrev;
  logic [SU_W-1:0]   suCnt;
  logic [LIM_W-1:0]  gapCnt;
  logic [MEAS_W-1:0] measDone;
  logic              started;
  logic [MEAS_W-1:0] measTarget;
  logic [LIM_W:0]    gapNext;

  // two measurements per bit: 3, 6 or 9 bits
  always_comb begin
    case (bitSel)
      2'd0:    measTarget = MEAS_W'(6);
      2'd1:    measTarget = MEAS_W'(12);
      default: measTarget = MEAS_W'(18);
    endcase
  end

  assign gapNext = {1'b0, gapCnt} + 1'b1;

  always_comb begin
    status.edgeSeen = tick && (demodIn != demodPrev);
    status.suLast   = (suCnt == SU_LAST);
    status.timing   = started;
    status.tooShort = (gapCnt < limMin);
    status.tooLong  = (gapNext >= {1'b0, limMax});
    status.lastMeas = ((measDone + 1'b1) == measTarget);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      demodPrev <= 1'b0;
    end else if (tick) begin
      demodPrev <= demodIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suCnt    <= '0;
      gapCnt   <= '0;
      measDone <= '0;
      started  <= 1'b0;
    end else if (strobe.clearAll) begin
      suCnt    <= '0;
      gapCnt   <= '0;
      measDone <= '0;
      started  <= 1'b0;
    end else begin
      if (strobe.suInc) begin
        suCnt <= suCnt + 1'b1;
      end
      if (strobe.startTiming) begin
        started <= 1'b1;
        gapCnt  <= LIM_W'(1);
      end else if (strobe.accept) begin
        gapCnt   <= LIM_W'(1);
        measDone <= measDone + 1'b1;
      end else if (strobe.cntInc) begin
        gapCnt <= gapNext[LIM_W-1:0];
      end
    end
  end

  AST_MEAS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    measDone < MEAS_W'(18)); // R7

  AST_TIMING_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (gapCnt != '0)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (!started && measDone == '0 && suCnt == '0)); // R9

endmodule

// File: rtl/bitcheck_ctrl.sv
module bitcheck_ctrl
  import bitcheck_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  bcStatus_t  status,
  output bcStrobe_t  strobe,
  output logic       passPulse,
  output logic       failPulse,
  output logic [1:0] mode
);

  bcState_t state, nextState;
  logic passNext, failNext;

  always_comb begin
    nextState = state;
    strobe    = '0;
    passNext  = 1'b0;
    failNext  = 1'b0;
    if (!enable) begin
      nextState       = ST_IDLE;
      strobe.clearAll = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          nextState       = ST_STARTUP;
          strobe.clearAll = 1'b1;
        end
        ST_STARTUP: begin
          if (tick) begin
            if (status.suLast) nextState = ST_CHECK;
            else               strobe.suInc = 1'b1;
          end
        end
        ST_CHECK: begin
          if (tick) begin
            if (!status.timing) begin
              if (status.edgeSeen) strobe.startTiming = 1'b1;
            end else if (status.edgeSeen) begin
              if (status.tooShort) begin
                failNext  = 1'b1;
                nextState = ST_SLEEP;
              end else if (status.lastMeas) begin
                passNext  = 1'b1;
                nextState = ST_RECEIVE;
              end else begin
                strobe.accept = 1'b1;
              end
            end else if (status.tooLong) begin
              failNext  = 1'b1;
              nextState = ST_SLEEP;
            end else begin
              strobe.cntInc = 1'b1;
            end
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      passPulse <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      state     <= nextState;
      passPulse <= passNext;
      failPulse <= failNext;
    end
  end

  always_comb begin
    case (state)
      ST_STARTUP: mode = MODE_STARTUP;
      ST_CHECK:   mode = MODE_CHECK;
      ST_RECEIVE: mode = MODE_RECEIVE;
      default:    mode = MODE_SLEEP;
    endcase
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(passPulse && failPulse)); // R7

  AST_FAIL_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> (mode == MODE_SLEEP)); // R4

  AST_PASS_RECEIVE: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |-> (mode == MODE_RECEIVE)); // R7

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && enable) |=> (state == ST_SLEEP && !passPulse && !failPulse)); // R8

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (mode == MODE_SLEEP && !passPulse && !failPulse)); // R9

  AST_STARTUP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STARTUP && $past(state) != ST_STARTUP) |-> ($past(state) == ST_IDLE)); // R2

endmodule

// File: rtl/bitcheck_validator.sv
module bitcheck_validator
  import bitcheck_pkg::*;
#(
  parameter int LIM_W = 6,
  parameter int STARTUP_TICKS = 8,
  parameter int MEAS_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             tick,
  input  logic             demodIn,
  input  logic [LIM_W-1:0] limMin,
  input  logic [LIM_W-1:0] limMax,
  input  logic [1:0]       bitSel,
  output logic             passPulse,
  output logic             failPulse,
  output logic [1:0]       mode
);

  bcStrobe_t strobe;
  bcStatus_t status;

  bitcheck_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .tick      (tick),
    .status    (status),
    .strobe    (strobe),
    .passPulse (passPulse),
    .failPulse (failPulse),
    .mode      (mode)
  );

  bitcheck_datapath #(
    .LIM_W         (LIM_W),
    .STARTUP_TICKS (STARTUP_TICKS),
    .MEAS_W        (MEAS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .demodIn (demodIn),
    .limMin  (limMin),
    .limMax  (limMax),
    .bitSel  (bitSel),
    .strobe  (strobe),
    .status  (status)
  );

endmodule

// File: tb/bitcheck_validator_test.sv
module bitcheck_validator_test;

  localparam int SU = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic demodIn = 1'b0;
  logic [5:0] limMin = 6'd14;
  logic [5:0] limMax = 6'd24;
  logic [1:0] bitSel = 2'd0;
  logic passPulse, failPulse;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;
  logic lvl = 1'b0;

  always #2.5 clk = ~clk;

  bitcheck_validator uut (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .demodIn(demodIn),
    .limMin(limMin), .limMax(limMax), .bitSel(bitSel),
    .passPulse(passPulse), .failPulse(failPulse), .mode(mode)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req, input int expMode, input logic expPass, input logic expFail);
    check(mode == expMode[1:0], {req, " mode"}, mode, expMode);
    check(passPulse == expPass, {req, " pass"}, passPulse, expPass);
    check(failPulse == expFail, {req, " fail"}, failPulse, expFail);
  endtask

  // one sample tick carrying level d; returns where the result is visible
  task automatic doTick(input logic d);
    @(negedge clk);
    demodIn = d;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) doTick(lvl);
  endtask

  task automatic edgeTick();
    lvl = ~lvl;
    doTick(lvl);
  endtask

  // a gap of k ticks ending in an edge
  task automatic gap(input int k);
    quiet(k - 1);
    edgeTick();
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
  endtask

  // enable, run start-up (toggling data), enter check, first edge
  task automatic startRun(input logic withFirstEdge);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    for (int i = 0; i < SU - 1; i++) edgeTick();
    checkOut("R2 startup", 1, 1'b0, 1'b0);
    edgeTick();
    checkOut("R2 enter check", 2, 1'b0, 1'b0);
    if (withFirstEdge) edgeTick();
  endtask

  task automatic testReset();
    checkOut("R1 reset", 0, 1'b0, 1'b0);
    quiet(3);
    checkOut("R1 enable low", 0, 1'b0, 1'b0);
  endtask

  task automatic testFirstEdge();
    bitSel = 2'd0;
    startRun(1'b0);
    quiet(40);
    checkOut("R3 quiet before first edge", 2, 1'b0, 1'b0);
    edgeTick();
    checkOut("R3 first edge unchecked", 2, 1'b0, 1'b0);
    gap(14);
    checkOut("R3 timing started", 2, 1'b0, 1'b0);
    stopRun();
  endtask

  task automatic testTooShort();
    startRun(1'b1);
    gap(13);
    checkOut("R4 short gap", 0, 1'b0, 1'b1);
    @(negedge clk);
    check(failPulse == 1'b0, "R4 one-cycle fail", failPulse, 0);
    for (int i = 0; i < 10; i++) edgeTick();
    quiet(30);
    checkOut("R8 sleep held", 0, 1'b0, 1'b0);
    stopRun();
    checkOut("R1 idle after sleep", 0, 1'b0, 1'b0);
  endtask

  task automatic testTooLong();
    startRun(1'b1);
    quiet(22);
    checkOut("R5 before limit", 2, 1'b0, 1'b0);
    quiet(1);
    checkOut("R5 limit reached", 0, 1'b0, 1'b1);
    stopRun();
  endtask

  task automatic testBoundaries();
    bitSel = 2'd0;
    startRun(1'b1);
    gap(14);
    checkOut("R6 gap at min", 2, 1'b0, 1'b0);
    gap(23);
    checkOut("R6 gap at max-1", 2, 1'b0, 1'b0);
    gap(14);
    checkOut("R6 counter restart", 2, 1'b0, 1'b0);
    stopRun();
  endtask

  task automatic testCount(input logic [1:0] sel, input int meas);
    bitSel = sel;
    startRun(1'b1);
    for (int i = 0; i < meas - 1; i++) gap(16);
    checkOut("R7 before last", 2, 1'b0, 1'b0);
    gap(16);
    checkOut("R7 pass", 3, 1'b1, 1'b0);
    @(negedge clk);
    check(passPulse == 1'b0, "R7 one-cycle pass", passPulse, 0);
    check(mode == 2'd3, "R7 receive held", mode, 3);
    stopRun();
  endtask

  task automatic testAbort();
    bitSel = 2'd0;
    startRun(1'b1);
    gap(16);
    gap(16);
    gap(16);
    stopRun();
    checkOut("R9 disable mid-check", 0, 1'b0, 1'b0);
    // fresh run must need a full start-up and full 6 gaps
    startRun(1'b1);
    for (int i = 0; i < 5; i++) gap(16);
    checkOut("R9 no stale count", 2, 1'b0, 1'b0);
    gap(16);
    checkOut("R9 fresh pass", 3, 1'b1, 1'b0);
    stopRun();
  endtask

  initial begin
    #500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstEdge();
    testTooShort();
    testTooLong();
    testBoundaries();
    testCount(2'd0, 6);
    testCount(2'd1, 12);
    testCount(2'd2, 18);
    testCount(2'd3, 18);
    testAbort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule